// File: doc/BRIEF.md
# Bit Manipulation Bus Decorator

This block sits between a bus master and a peripheral bus and gives the master single-access bit operations on peripheral registers. The master issues a load or store to an alias address. Upper address bits in the alias name an operation, a bit position and a field width. The block then runs its own read, compute and write sequence on the real register. Stores can perform AND, OR, XOR or a field insert with the store data. Loads can perform load-and-clear-one-bit, load-and-set-one-bit or an unsigned field extract. Accesses outside the alias space pass straight through in the same cycle.

Both sides use a valid/ready handshake. Read data is valid in the cycle that ready is high. During a decorated access the master sees ready only after the peripheral accepts the write-back, plus one response cycle. A field extract skips the write-back. Operands, masks and write-back values are cut to the access size of byte, halfword or word, with data right-justified on the 32-bit data lines.

Top module: `bitop_alias_bridge`

## Requirements
- R1: After reset, with no request, the block drives no peripheral request (p_valid low) and m_ready is low.
- R2: An access whose address[31:29] is not 3'b010 is forwarded in the same cycle with address, direction, size and data unchanged. Its read data and ready return unchanged. A lone access with a zero-wait peripheral completes with ready in its first cycle.
- R3: A store with address[31:29]=3'b010 and address[28:26] equal to 001 (AND), 010 (OR) or 011 (XOR) targets 0x4000_0000 plus address[19:0]. The target is written with its old value combined with the write data by that operation.
- R4: A store with address[31:29]=3'b010 and address[28]=1 is a field insert. Bit position b is address[27:23], width code w is address[22:19] and the target is 0x4000_0000 plus address[18:0]. With mask = ((2^(w+1))-1)<<b, the target is written with (old & ~mask) | (wdata & mask). A width code of 15 gives a 16-bit field.
- R5: A load with address[28:26]=010 (clear) or 011 (set) and bit number n in address[25:21] returns the old value of the target at 0x4000_0000 plus address[19:0]. It then writes the old value back with bit n cleared or set.
- R6: A load with address[31:29]=3'b010 and address[28]=1 returns the w+1 bits of the target starting at bit b, right-justified and zero-extended. It issues no peripheral write.
- R7: Access size is encoded 00 byte, 01 halfword, 10 word. The old value, the write data, every mask and the write-back are cut to that size. A field or bit beyond the size reads as zero and changes nothing.
- R8: The load-and-set/clear write-back carries every other bit of the old value. Write-one-to-clear flags that read as 1 are therefore cleared. A field insert writes the data bits inside the mask and the old bits outside it.
- R9: A load with address[31:29]=3'b010 and address[28:26]=001 names no operation. It is forwarded as a plain read of 0x4000_0000 plus address[19:0], with no write.
- R10: During a decorated access m_ready stays low through the read, compute and write steps. It is high for exactly one cycle, the cycle after the write-back is accepted, or after the compute step for an extract. Peripheral wait states stretch each step, and the request is held stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Master request accepted / read data valid |
| m_write | input | 1 | Master request is a store |
| m_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| m_addr | input | 32 | Master address, plain or alias |
| m_wdata | input | 32 | Store data, right-justified |
| m_rdata | output | 32 | Load data, right-justified |
| p_valid | output | 1 | Peripheral request valid |
| p_ready | input | 1 | Peripheral request accepted |
| p_write | output | 1 | Peripheral request is a write |
| p_size | output | 2 | Peripheral access size |
| p_addr | output | 32 | Peripheral register address |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data, valid with p_ready on a read |

## Verification
The checker assumes the master holds a request and its fields steady until it sees m_ready. It also assumes the peripheral returns read data in the cycle it raises p_ready. The bench drives each request at a falling edge and keeps it until ready is seen, then drops it at the next falling edge. Its peripheral model raises ready only while a request is present, after a programmable number of wait cycles, so both zero-wait and stretched handshakes stay within those assumptions. The alias addresses used all carry a size and offset that fall inside the modelled register set.

// File: rtl/bab_pkg.sv
package bab_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN, OP_AND, OP_OR, OP_XOR, OP_INS, OP_LCLR, OP_LSET, OP_XTR
  } bab_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CALC, ST_WR, ST_RESP
  } bab_st_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/bab_decode.sv
module bab_decode
  import bab_pkg::*;
#(
  parameter logic [31:0] BASE      = 32'h4000_0000,
  parameter int          LOG_OFF_W = 20,
  parameter int          FLD_OFF_W = 19
) (
  input  logic [31:0] addr,
  input  logic        write,
  output bab_op_e     op,
  output logic [31:0] tgt,
  output logic [4:0]  pos,
  output logic [3:0]  wcode,
  output logic [4:0]  bitn
);
  localparam logic [2:0] TAG = BASE[31:29];

  logic alias_hit;
  logic [31:0] log_tgt, fld_tgt;

  assign alias_hit = (addr[31:29] == TAG) && (addr[28:26] != 3'b000);
  assign log_tgt   = BASE | {{(32-LOG_OFF_W){1'b0}}, addr[LOG_OFF_W-1:0]};
  assign fld_tgt   = BASE | {{(32-FLD_OFF_W){1'b0}}, addr[FLD_OFF_W-1:0]};
  assign pos       = addr[27:23];
  assign wcode     = addr[22:19];
  assign bitn      = addr[25:21];

  always_comb begin
    op  = OP_PLAIN;
    tgt = addr;
    if (alias_hit) begin
      if (addr[28]) begin
        op  = write ? OP_INS : OP_XTR;
        tgt = fld_tgt;
      end else begin
        tgt = log_tgt;
        unique case (addr[27:26])
          2'b01:   op = write ? OP_AND : OP_PLAIN;
          2'b10:   op = write ? OP_OR  : OP_LCLR;
          default: op = write ? OP_XOR : OP_LSET;
        endcase
      end
    end
  end
endmodule

// File: rtl/bab_alu.sv
module bab_alu
  import bab_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bab_op_e           op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] old,
  input  logic [DATA_W-1:0] wdata,
  input  logic [4:0]        pos,
  input  logic [3:0]        wcode,
  input  logic [4:0]        bitn,
  output logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] rd_val,
  output logic              do_wr
);
  logic [DATA_W-1:0] szm, o, d, fmask, bmask, res;
  logic [DATA_W:0]   ones;

  always_comb begin
    unique case (size)
      SZ_BYTE: szm = DATA_W'(8'hFF);
      SZ_HALF: szm = DATA_W'(16'hFFFF);
      default: szm = '1;
    endcase
  end

  assign o     = old & szm;
  assign d     = wdata & szm;
  assign ones  = ({{DATA_W{1'b0}}, 1'b1} << ({1'b0, wcode} + 5'd1)) - 1'b1;
  assign fmask = (ones[DATA_W-1:0] << pos) & szm;
  assign bmask = ({{(DATA_W-1){1'b0}}, 1'b1} << bitn) & szm;
  assign do_wr = (op != OP_XTR);

  always_comb begin
    res    = o;
    rd_val = '0;
    unique case (op)
      OP_AND:  res = o & d;
      OP_OR:   res = o | d;
      OP_XOR:  res = o ^ d;
      OP_INS:  res = (o & ~fmask) | (d & fmask);
      OP_LCLR: begin res = o & ~bmask; rd_val = o; end
      OP_LSET: begin res = o | bmask;  rd_val = o; end
      OP_XTR:  rd_val = (o >> pos) & ones[DATA_W-1:0];
      default: rd_val = o;
    endcase
    wr_val = res & szm;
  end
endmodule

// File: rtl/bitop_alias_bridge.sv
module bitop_alias_bridge
  import bab_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] BASE   = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic              m_write,
  input  logic [1:0]        m_size,
  input  logic [31:0]       m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  output logic              p_valid,
  input  logic              p_ready,
  output logic              p_write,
  output logic [1:0]        p_size,
  output logic [31:0]       p_addr,
  output logic [DATA_W-1:0] p_wdata,
  input  logic [DATA_W-1:0] p_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  bab_st_e st_q, st_d;
  bab_op_e op_q, dec_op;
  logic [1:0]        size_q;
  logic [31:0]       tgt_q, dec_tgt;
  logic [DATA_W-1:0] wd_q, old_q, wr_q, rsp_q, alu_wr, alu_rd;
  logic [4:0]        pos_q, bn_q, dec_pos, dec_bn;
  logic [3:0]        wc_q, dec_wc;
  logic              alu_do_wr;
  logic              ld_req, ld_old, ld_res;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  bab_decode #(.BASE(BASE)) u_dec (
    .addr(m_addr), .write(m_write), .op(dec_op), .tgt(dec_tgt),
    .pos(dec_pos), .wcode(dec_wc), .bitn(dec_bn)
  );

  bab_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .size(size_q), .old(old_q), .wdata(wd_q),
    .pos(pos_q), .wcode(wc_q), .bitn(bn_q),
    .wr_val(alu_wr), .rd_val(alu_rd), .do_wr(alu_do_wr)
  );

  // next state and enables
  always_comb begin
    st_d   = st_q;
    ld_req = 1'b0;
    ld_old = 1'b0;
    ld_res = 1'b0;
    unique case (st_q)
      ST_IDLE: if (m_valid && dec_op != OP_PLAIN) begin
        st_d = ST_RD; ld_req = 1'b1;
      end
      ST_RD:   if (p_ready) begin st_d = ST_CALC; ld_old = 1'b1; end
      ST_CALC: begin ld_res = 1'b1; st_d = alu_do_wr ? ST_WR : ST_RESP; end
      ST_WR:   if (p_ready) st_d = ST_RESP;
      default: st_d = ST_IDLE;
    endcase
  end

  // bus outputs
  always_comb begin
    p_valid = 1'b0;
    p_write = m_write;
    p_size  = m_size;
    p_addr  = dec_tgt;
    p_wdata = m_wdata;
    m_ready = 1'b0;
    m_rdata = '0;
    unique case (st_q)
      ST_IDLE: if (dec_op == OP_PLAIN) begin
        p_valid = m_valid;
        m_ready = m_valid && p_ready;
        m_rdata = p_rdata;
      end
      ST_RD: begin
        p_valid = 1'b1; p_write = 1'b0; p_size = size_q;
        p_addr  = tgt_q; p_wdata = '0;
      end
      ST_WR: begin
        p_valid = 1'b1; p_write = 1'b1; p_size = size_q;
        p_addr  = tgt_q; p_wdata = wr_q;
      end
      ST_RESP: begin
        m_ready = 1'b1;
        m_rdata = rsp_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      op_q   <= dec_op;
      size_q <= m_size;
      tgt_q  <= dec_tgt;
      wd_q   <= m_wdata;
      pos_q  <= dec_pos;
      wc_q   <= dec_wc;
      bn_q   <= dec_bn;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_old) old_q <= p_rdata;
  end

  always_ff @(posedge clk) begin
    if (ld_res) begin
      wr_q  <= alu_wr;
      rsp_q <= alu_rd;
    end
  end
endmodule

// File: rtl/bab_checker.sv
module bab_checker
  import bab_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] BASE   = 32'h4000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_write,
  input logic [31:0]       m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              p_valid,
  input logic              p_ready,
  input logic              p_write,
  input logic [31:0]       p_addr,
  input logic [DATA_W-1:0] p_wdata,
  input bab_st_e           st,
  input bab_op_e           op,
  input logic [1:0]        sz
);
  p_plain_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && m_valid && m_addr[31:29] != BASE[31:29]) |->
      (p_valid && p_addr == m_addr && p_wdata == m_wdata && p_write == m_write));

  p_target_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD || st == ST_WR) |-> (p_addr[31:20] == BASE[31:20]));

  p_extract_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XTR && st != ST_IDLE) |-> !(p_valid && p_write));

  p_byte_wdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && sz == SZ_BYTE) |-> (p_wdata[DATA_W-1:8] == '0));

  p_hold_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD || st == ST_CALC || st == ST_WR) |-> !m_ready);

  p_resp_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RESP) |=> (st == ST_IDLE && $past(m_ready)));

  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && p_valid && !p_ready) |=>
      (p_valid && $stable(p_addr) && $stable(p_write) && $stable(p_wdata)));
endmodule

bind bitop_alias_bridge bab_checker #(.DATA_W(DATA_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
  .p_valid(p_valid), .p_ready(p_ready), .p_write(p_write),
  .p_addr(p_addr), .p_wdata(p_wdata),
  .st(st_q), .op(op_q), .sz(size_q)
);

// File: tb/tb_bitop_alias_bridge.sv
module tb_bitop_alias_bridge;
  logic        clk, rst_n;
  logic        m_valid, m_ready, m_write;
  logic [1:0]  m_size, p_size;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        p_valid, p_ready, p_write;
  logic [31:0] p_addr, p_wdata, p_rdata;

  int checks = 0, errors = 0;
  int stall = 0, wcnt = 0, nwr = 0;
  logic [31:0] regs [16];
  logic [31:0] last_wa, last_ra;

  bitop_alias_bridge dut (.*);

  initial begin clk = 1'b0; forever #4 clk = ~clk; end

  function automatic logic [31:0] szm(logic [1:0] s);
    return (s == 2'b00) ? 32'hFF : (s == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // peripheral model: 16 registers, index 15 is write-one-to-clear
  assign p_ready = p_valid && (wcnt >= stall);
  assign p_rdata = regs[p_addr[5:2]] & szm(p_size);

  always @(posedge clk) begin
    if (p_valid && !p_ready) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (p_valid && p_ready) begin
      if (p_write) begin
        nwr     <= nwr + 1;
        last_wa <= p_addr;
        if (p_addr[5:2] == 4'd15)
          regs[15] <= regs[15] & ~(p_wdata & szm(p_size));
        else
          regs[p_addr[5:2]] <= (regs[p_addr[5:2]] & ~szm(p_size)) | (p_wdata & szm(p_size));
      end else begin
        last_ra <= p_addr;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic wr, input logic [1:0] s,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    waits = 0;
    rd    = '0;
    @(negedge clk);
    m_valid = 1'b1; m_addr = a; m_write = wr; m_size = s; m_wdata = wd;
    forever begin
      #1;
      if (m_ready) begin rd = m_rdata; break; end
      if (waits > 200) begin chk("R10 watchdog", 32'd0, 32'd1); break; end
      @(negedge clk);
      waits++;
    end
    @(negedge clk);
    m_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 p_valid", {31'd0, p_valid}, 32'd0);
    chk("R1 m_ready", {31'd0, m_ready}, 32'd0);
  endtask

  task automatic t_plain;
    logic [31:0] rd; int w;
    regs[3] = 32'h1122_3344;
    acc(32'h4000_000C, 1'b0, 2'b10, 32'h0, rd, w);
    chk("R2 plain read", rd, 32'h1122_3344);
    chk("R2 plain read latency", w, 0);
    acc(32'h4000_0010, 1'b1, 2'b10, 32'hCAFE_F00D, rd, w);
    chk("R2 plain write", regs[4], 32'hCAFE_F00D);
    chk("R2 plain write addr", last_wa, 32'h4000_0010);
  endtask

  task automatic t_logic;
    logic [31:0] rd; int w;
    regs[2] = 32'hF0F0_1234;
    acc(32'h4400_0008, 1'b1, 2'b10, 32'h0FF0_FFFF, rd, w);
    chk("R3 and", regs[2], 32'h00F0_1234);
    chk("R10 rmw latency", w, 4);
    acc(32'h4800_0008, 1'b1, 2'b10, 32'h0000_000F, rd, w);
    chk("R3 or", regs[2], 32'h00F0_123F);
    acc(32'h4C0F_F008, 1'b1, 2'b10, 32'hFFFF_0000, rd, w);
    chk("R3 xor", regs[2], 32'hFF0F_123F);
    chk("R3 20-bit offset", last_wa, 32'h400F_F008);
  endtask

  task automatic t_insert;
    logic [31:0] rd; int w;
    regs[5] = 32'hFFFF_FFFF;
    acc(32'h5000_0014 | (32'd4 << 23) | (32'd3 << 19), 1'b1, 2'b10, 32'h0000_00A0, rd, w);
    chk("R4 insert nibble", regs[5], 32'hFFFF_FFAF);
    chk("R4 19-bit offset", last_wa, 32'h4000_0014);
    regs[5] = 32'h0;
    acc(32'h5000_0014 | (32'd5 << 23) | (32'd1 << 19), 1'b1, 2'b10, 32'h0000_0040, rd, w);
    chk("R4 insert 2-bit", regs[5], 32'h0000_0040);
    regs[5] = 32'h1234_5678;
    acc(32'h5000_0014 | (32'd16 << 23) | (32'd15 << 19), 1'b1, 2'b10, 32'hABCD_0000, rd, w);
    chk("R4 insert 16-bit", regs[5], 32'hABCD_5678);
  endtask

  task automatic t_loadbit;
    logic [31:0] rd; int w;
    regs[6] = 32'h0000_00F0;
    acc(32'h4800_0018 | (32'd5 << 21), 1'b0, 2'b10, 32'h0, rd, w);
    chk("R5 clear returns old", rd, 32'h0000_00F0);
    chk("R5 clear writes", regs[6], 32'h0000_00D0);
    acc(32'h4C00_0018, 1'b0, 2'b10, 32'h0, rd, w);
    chk("R5 set returns old", rd, 32'h0000_00D0);
    chk("R5 set writes", regs[6], 32'h0000_00D1);
  endtask

  task automatic t_extract;
    logic [31:0] rd; int w, n0;
    regs[7] = 32'h3A;
    n0 = nwr;
    acc(32'h5000_001C | (32'd1 << 23) | (32'd1 << 19), 1'b0, 2'b10, 32'h0, rd, w);
    chk("R6 extract 0x3A", rd, 32'h1);
    chk("R10 extract latency", w, 3);
    regs[7] = 32'h35;
    acc(32'h5000_001C | (32'd1 << 23) | (32'd1 << 19), 1'b0, 2'b10, 32'h0, rd, w);
    chk("R6 extract 0x35", rd, 32'h2);
    regs[7] = 32'hA500_0000;
    acc(32'h5000_001C | (32'd24 << 23) | (32'd7 << 19), 1'b0, 2'b10, 32'h0, rd, w);
    chk("R6 extract top byte", rd, 32'hA5);
    chk("R6 no write", nwr, n0);
  endtask

  task automatic t_size;
    logic [31:0] rd; int w;
    regs[8] = 32'h1234_5678;
    acc(32'h4800_0020, 1'b1, 2'b00, 32'hFFFF_FF01, rd, w);
    chk("R7 byte or", regs[8], 32'h1234_5679);
    acc(32'h4C00_0020, 1'b1, 2'b01, 32'hFFFF_FFFF, rd, w);
    chk("R7 half xor", regs[8], 32'h1234_A986);
    regs[9] = 32'hFFFF_FFFF;
    acc(32'h5000_0024 | (32'd4 << 23) | (32'd7 << 19), 1'b0, 2'b00, 32'h0, rd, w);
    chk("R7 byte extract", rd, 32'h0F);
    regs[10] = 32'h11;
    acc(32'h4C00_0028 | (32'd12 << 21), 1'b0, 2'b00, 32'h0, rd, w);
    chk("R7 byte set beyond size rd", rd, 32'h11);
    chk("R7 byte set beyond size reg", regs[10], 32'h11);
  endtask

  task automatic t_w1c;
    logic [31:0] rd; int w;
    regs[15] = 32'h107;
    acc(32'h4C00_003C | (32'd1 << 21), 1'b0, 2'b10, 32'h0, rd, w);
    chk("R8 set returns flags", rd, 32'h107);
    chk("R8 set clears all flags", regs[15], 32'h0);
    regs[15] = 32'h107;
    acc(32'h5000_003C | (32'd0 << 23) | (32'd8 << 19), 1'b1, 2'b10, 32'h001, rd, w);
    chk("R8 insert clears one flag", regs[15], 32'h106);
  endtask

  task automatic t_undef;
    logic [31:0] rd; int w, n0;
    regs[3] = 32'h5566_7788;
    n0 = nwr;
    acc(32'h4400_000C, 1'b0, 2'b10, 32'h0, rd, w);
    chk("R9 plain data", rd, 32'h5566_7788);
    chk("R9 plain addr", last_ra, 32'h4000_000C);
    chk("R9 no write", nwr, n0);
  endtask

  task automatic t_stall;
    logic [31:0] rd; int w;
    stall = 3;
    regs[11] = 32'h0000_FF00;
    acc(32'h4400_002C, 1'b1, 2'b10, 32'h0000_0F0F, rd, w);
    chk("R10 stalled result", regs[11], 32'h0000_0F00);
    chk("R10 stalled latency", w, 10);
    stall = 0;
  endtask

  initial begin
    #(8 * 200000);
    chk("watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    m_valid = 1'b0; m_write = 1'b0; m_size = 2'b10; m_addr = '0; m_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_plain;
    t_logic;
    t_insert;
    t_loadbit;
    t_extract;
    t_size;
    t_w1c;
    t_undef;
    t_stall;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule